// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave is holding by keeping SDA low after it stopped in the middle of a byte. When a request arrives, the sequencer takes over the open-drain SCL and SDA drivers and releases both lines. It then checks SDA once per half period of the recovery clock. For as long as SDA reads low, it issues SCL pulses so the slave can clock out the rest of its byte and its acknowledge bit. The number of pulses has an upper limit. After the pulse loop it always drives a STOP condition and then gives the lines back to the main controller.

Completion is shown by a one-cycle done pulse. A sticky fail flag reports two cases: SDA is still low after the last allowed pulse, or an overall timeout expired before the sequence finished. Both the half period and the timeout are given in system clock cycles. Resetting the main master and retrying the failed transfer are left to the logic around this block.

States:
- `ST_IDLE`: the lines are released and the block does not own the bus.
- `ST_RELEASE`: one half period with both lines released.
- `ST_CLK_LO` and `ST_CLK_HI`: the two halves of one recovery pulse.
- `ST_STOP_A` to `ST_STOP_D`: the four half-period steps of the STOP.

Transitions:
- start: IDLE→RELEASE.
- sample-low: RELEASE/CLK_HI→CLK_LO. SDA is low and pulses remain.
- sample-done: RELEASE/CLK_HI→STOP_A. SDA is high, or the pulse cap is reached.
- half-step: CLK_LO→CLK_HI, then STOP_A→STOP_B→STOP_C→STOP_D.
- finish: STOP_D→IDLE.
- abort: any busy state→IDLE when the timeout expires.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `done` and `fail` are all 0. An oe value of 1 pulls its line low.
- R2: A start accepted in idle releases both lines for exactly one half period (HALF_CYC cycles). SDA is sampled at the end of that half period.
- R3: Each recovery pulse holds `scl_oe`=1 for HALF_CYC cycles, then releases SCL for HALF_CYC cycles. SDA is sampled at the end of the released half, and pulsing stops at the first sample that reads high.
- R4: No more than MAX_PULSES (default 9) pulses are issued per sequence.
- R5: The STOP runs these steps, each held for HALF_CYC cycles: SCL low; then SCL and SDA low; then SCL released with SDA low; then both released. SDA is only pulled low while SCL is pulled low, and SDA is only released while SCL is released.
- R6: `done` is high for exactly one cycle. With p pulses and no timeout, it appears HALF_CYC*(5+2p) clock edges after the edge that accepted the start.
- R7: `fail` is set when SDA still reads low at the sample after the final allowed pulse. It stays set until the next accepted start clears it.
- R8: If TIMEOUT_CYC edges pass after the accepted start with the sequence still running, the block releases both lines, pulses `done`, sets `fail` and returns to idle.
- R9: A start that arrives while the sequence runs is ignored, and the sequence length and outputs are unchanged.
- R10: `busy` is high from the edge that accepts a start until the edge that produces `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run a bus-clear sequence |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequencer owns the bus lines |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| fail | output | 1 | Sticky: the bus could not be freed or the timeout expired |

## Verification
The hardest situation to reach from the ports is the timeout abort. The pulse loop is bounded, so a correctly sized timeout never fires during normal operation. The bench therefore runs a second instance whose timeout is shorter than a three-pulse sequence, and it makes the slave model release SDA only after the third rising SCL edge, so the abort lands in the middle of the STOP. The slave model releases SDA after a chosen number of rising SCL edges, anywhere from none to more than the cap. This exercises the early exit, the release exactly at the cap, and the failure just past the cap.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C,
        ST_STOP_D
    } bc_state_t;

endpackage

// File: rtl/bc_halfper.sv
module bc_halfper #(
    parameter int HALF_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

    logic [TW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R3

endmodule

// File: rtl/bc_timeout.sv
module bc_timeout #(
    parameter int LIMIT = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic expire
);
    localparam int LW = $clog2(LIMIT + 1);
    localparam logic [LW-1:0] LAST = LW'(LIMIT - 1);

    logic [LW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (arm) begin
            cnt <= '0;
        end else if (run && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt <= LAST); // R8

endmodule

// File: rtl/bc_fsm.sv
module bc_fsm
    import i2c_bc_pkg::*;
#(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    input  logic sda_in,
    input  logic expire,
    output logic accept,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail
);
    localparam int PW = $clog2(MAX_PULSES + 1);
    localparam logic [PW-1:0] CAP = PW'(MAX_PULSES);

    bc_state_t state, state_nx;
    logic [PW-1:0] pcnt;
    logic          sample, more;

    assign accept = (state == ST_IDLE) && start;
    assign sample = tick && (state == ST_RELEASE || state == ST_CLK_HI);
    assign more   = !sda_in && (pcnt < CAP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_RELEASE;
            ST_RELEASE,
            ST_CLK_HI:  if (tick) state_nx = more ? ST_CLK_LO : ST_STOP_A;
            ST_CLK_LO:  if (tick) state_nx = ST_CLK_HI;
            ST_STOP_A:  if (tick) state_nx = ST_STOP_B;
            ST_STOP_B:  if (tick) state_nx = ST_STOP_C;
            ST_STOP_C:  if (tick) state_nx = ST_STOP_D;
            ST_STOP_D:  if (tick) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
        if (expire && state != ST_IDLE) state_nx = ST_IDLE;
    end

    // line drivers
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_CLK_LO, ST_STOP_A: scl_oe = 1'b1;
            ST_STOP_B: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_STOP_C: sda_oe = 1'b1;
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    assign busy = (state != ST_IDLE);

    // pulse counter and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            done <= 1'b0;
            fail <= 1'b0;
        end else begin
            done <= expire || (state == ST_STOP_D && tick);
            if (accept) begin
                pcnt <= '0;
                fail <= 1'b0;
            end else begin
                if (!expire && sample && more) pcnt <= pcnt + 1'b1;
                if (expire || (sample && !sda_in && pcnt == CAP)) fail <= 1'b1;
            end
        end
    end

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= CAP); // R4
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_RELEASE && start) |=> state != ST_RELEASE); // R9
    AST_STOP_SDA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe); // R5
    AST_STOP_SDA_REL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe); // R5

endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
    parameter int HALF_CYC    = 1250,
    parameter int MAX_PULSES  = 9,
    parameter int TIMEOUT_CYC = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic fail
);
    logic accept, tick, expire;

    bc_halfper #(.HALF_CYC(HALF_CYC)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    bc_timeout #(.LIMIT(TIMEOUT_CYC)) u_to (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (accept),
        .run    (busy),
        .expire (expire)
    );

    bc_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tick   (tick),
        .sda_in (sda_in),
        .expire (expire),
        .accept (accept),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe),
        .busy   (busy),
        .done   (done),
        .fail   (fail)
    );

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R1
    AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!busy && fail && done)); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

endmodule

// File: tb/sim_i2c_bus_clear.sv
`timescale 1ns/1ps
module sim_i2c_bus_clear;
    localparam int HALF = 4;
    localparam int MAXP = 9;
    localparam int TO0  = 1000;
    localparam int TO1  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start0 = 1'b0, start1 = 1'b0;
    logic sel = 1'b0;
    logic slave_load = 1'b0;
    logic hold = 1'b0;
    logic scl_prev = 1'b1;
    int   k_target = 0;
    int   edges = 0;
    int   cyc = 0;
    int   total = 0, bad = 0;

    logic scl_oe0, sda_oe0, busy0, done0, fail0;
    logic scl_oe1, sda_oe1, busy1, done1, fail1;
    logic o_scl, o_sda, o_busy, o_done, o_fail, scl_line, sda_line;

    assign o_scl  = sel ? scl_oe1 : scl_oe0;
    assign o_sda  = sel ? sda_oe1 : sda_oe0;
    assign o_busy = sel ? busy1 : busy0;
    assign o_done = sel ? done1 : done0;
    assign o_fail = sel ? fail1 : fail0;
    assign scl_line = !o_scl;
    assign sda_line = !o_sda && !hold;

    always #2 clk = ~clk;

    i2c_bus_clear #(.HALF_CYC(HALF), .MAX_PULSES(MAXP), .TIMEOUT_CYC(TO0)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start0), .sda_in(sda_line),
        .scl_oe(scl_oe0), .sda_oe(sda_oe0), .busy(busy0), .done(done0), .fail(fail0));

    i2c_bus_clear #(.HALF_CYC(HALF), .MAX_PULSES(MAXP), .TIMEOUT_CYC(TO1)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start1), .sda_in(sda_line),
        .scl_oe(scl_oe1), .sda_oe(sda_oe1), .busy(busy1), .done(done1), .fail(fail1));

    // slave model: holds SDA low until it has seen k_target rising SCL edges
    always @(posedge clk) begin
        cyc <= cyc + 1;
        scl_prev <= scl_line;
        if (slave_load) begin
            edges <= 0;
            hold  <= (k_target > 0);
        end else if (scl_line && !scl_prev) begin
            edges <= edges + 1;
            if (edges + 1 >= k_target) hold <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        return (k > MAXP) ? MAXP : k;
    endfunction

    function automatic int exp_len(input int p);
        return HALF * (5 + 2 * p);
    endfunction

    function automatic bit exp_fail(input int k);
        return k > MAXP;
    endfunction

    task automatic run_trial(input int k, input bit inject, input bit which,
                             input int elen, input bit efail, input int erise);
        int  t0, rises, sda_pulls, n;
        bit  prev_scl, prev_sda, seen;
        sel = which;
        k_target = k;
        slave_load = 1'b1;
        @(negedge clk);
        slave_load = 1'b0;
        if (which) start1 = 1'b1; else start0 = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start0 = 1'b0;
        start1 = 1'b0;
        chk(o_fail == 1'b0, "R7 fail cleared by start", o_fail, 0);
        chk(o_busy == 1'b1, "R10 busy after start", o_busy, 1);
        chk(o_scl == 1'b0 && o_sda == 1'b0, "R2 lines released first", {o_scl, o_sda}, 0);
        rises = 0; sda_pulls = 0; n = 1; seen = 1'b0;
        prev_scl = scl_line; prev_sda = o_sda;
        while (!seen && n < 400) begin
            if (inject && n == HALF * 3) begin
                if (which) start1 = 1'b1; else start0 = 1'b1;
            end
            @(negedge clk);
            start0 = 1'b0;
            start1 = 1'b0;
            n++;
            if (scl_line && !prev_scl && !o_done) rises++;
            if (o_sda && !prev_sda) begin
                sda_pulls++;
                chk(o_scl == 1'b1, "R5 SDA pulled only with SCL low", o_scl, 1);
            end
            if (!o_sda && prev_sda)
                chk(o_scl == 1'b0, "R5 SDA released with SCL released", o_scl, 0);
            prev_scl = scl_line;
            prev_sda = o_sda;
            if (o_done) seen = 1'b1;
        end
        chk(seen && (cyc - t0 == elen + 1), "R6 done timing", cyc - t0, elen + 1);
        chk(o_fail == efail, "R7/R8 fail flag", o_fail, efail);
        if (erise >= 0) begin
            chk(rises == erise, "R3/R4 SCL rising edges", rises, erise);
            chk(sda_pulls == 1, "R5 one SDA pull in STOP", sda_pulls, 1);
        end
        @(negedge clk);
        chk(o_done == 1'b0, "R6 done single cycle", o_done, 0);
        chk(o_busy == 1'b0 && o_scl == 1'b0 && o_sda == 1'b0,
            "R10 idle released after done", {o_busy, o_scl, o_sda}, 0);
        chk(o_fail == efail, "R7 fail sticky", o_fail, efail);
    endtask

    task automatic std_trial(input int k, input bit inject);
        int p;
        p = exp_pulses(k);
        run_trial(k, inject, 1'b0, exp_len(p), exp_fail(k), p + 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(scl_oe0 == 0 && sda_oe0 == 0 && busy0 == 0 && done0 == 0 && fail0 == 0,
            "R1 reset state u0", {scl_oe0, sda_oe0, busy0, done0, fail0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scl_oe1 == 0 && sda_oe1 == 0 && busy1 == 0 && done1 == 0 && fail1 == 0,
            "R1 idle state u1", {scl_oe1, sda_oe1, busy1, done1, fail1}, 0);
        // directed corners
        std_trial(0, 1'b0);    // R2 no pulse needed
        std_trial(1, 1'b0);    // R3 single pulse
        std_trial(9, 1'b0);    // R4 release exactly at cap
        std_trial(10, 1'b0);   // R7 still low after cap
        std_trial(2, 1'b0);    // R7 cleared on next start
        std_trial(5, 1'b1);    // R9 start during sequence
        // timeout instance: abort lands in STOP
        run_trial(3, 1'b0, 1'b1, TO1, 1'b1, -1);   // R8
        run_trial(0, 1'b0, 1'b1, exp_len(0), 1'b0, 1); // R8 no spurious timeout
        // random mix
        for (int i = 0; i < 30; i++) begin
            std_trial($urandom_range(0, 12), $urandom_range(0, 3) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        wait (cyc >= 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule